// File: doc/BRIEF.md
# Double-Buffered 10-bit PWM Generator

This block produces a pulse-width-modulated level from an 8-bit period timer that runs on the system clock through a selectable divider. The comparison point is a 10-bit time base: the timer count forms the upper bits and two sub-count bits sit below it. These two bits advance once per divided clock, so one timer increment always spans four sub-steps. Software sets the period and a 10-bit duty value with plain register writes. It starts the timer, and it reads back the duty value that is currently in force.

The duty value is double buffered. Software writes a pending value at any time. That value is copied into an active latch only when the timer passes the period value, and the output is set high at that same boundary. The output falls when the time base reaches the active duty value. The output can therefore never show a truncated or stretched pulse caused by a write in mid-period. A sticky flag marks every period boundary. A separate output-enable level lets software keep the pin driver off until the first full period has begun.

Register map (3-bit address, 8-bit data): 0 period (RW), 1 pending duty upper byte (RW), 2 control (RW: [1:0] pending duty low bits, [3:2] divider select, [4] run, [5] output enable), 3 status ([0] boundary flag, write 1 to clear), 4 active duty upper byte (RO), 5 active duty low bits in [1:0] (RO). Addresses 6 and 7 read as zero.

Top module: `pwm10_gen`

## Requirements
- R1: After reset, pwm_out, pwm_oe and period_irq are 0 and every address reads back 0.
- R2: With divider select S (0,1,2,3 giving N = 1,4,16,64) and period value P, boundary flags occur every 4*N*(P+1) clock cycles.
- R3: For an active duty D with 0 < D < 4*(P+1), pwm_out is high in the first cycle of the period and stays high for exactly D*N cycles of it.
- R4: An active duty of 0 keeps pwm_out low for the whole period, including its first cycle.
- R5: An active duty of at least 4*(P+1) keeps pwm_out high for the entire period.
- R6: The pending duty (address 1 upper byte, control bits [1:0] lower bits) is copied into the active duty only at a period boundary. A write in mid-period leaves the current pulse unchanged and takes effect in the following period. Addresses 4 and 5 return the active duty.
- R7: Writes to addresses 4 and 5 do not change the active duty.
- R8: The boundary flag (status bit 0, mirrored on period_irq) sets at each boundary and holds until a write with bit 0 set to 1. A write with bit 0 set to 0 leaves it set.
- R9: With control bit 4 (run) at 0, the timer freezes, pwm_out holds its level and no boundary flag is raised.
- R10: pwm_oe follows control bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| pwm_out | output | 1 | PWM level |
| pwm_oe | output | 1 | Output driver enable level |
| period_irq | output | 1 | Sticky period-boundary flag |

## Verification
The assertions on full duty and on the latch timing assume that the period value is not rewritten while the timer runs. A lowered period could leave the timer above it, and the timer would then wrap through 255. The stimulus applies a reset before each configuration and writes the period before setting the run bit. The only register it writes during a run is the pending duty, which is the case that double buffering must absorb.

// File: rtl/pwm10_gen.sv
module pwm10_gen #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          pwm_out,
  output logic          pwm_oe,
  output logic          period_irq
);
  localparam int DW = TW + 2;
  localparam int CW = 8;

  logic [TW-1:0] per_q, dhi_q, act_hi_q, tmr_q;
  logic [1:0]    dlo_q, psel_q, act_lo_q, sub;
  logic          run_q, oe_q, flag_q, pwm_q;
  logic [CW-1:0] cnt_q, pmask;
  logic [DW-1:0] base, act, pend;
  logic          step, tick, wrap, wr_ctrl, psel_chg;

  assign pmask    = CW'((9'd1 << (2 * psel_q)) - 9'd1);
  assign sub      = cnt_q[2 * psel_q +: 2];
  assign step     = run_q && ((cnt_q & pmask) == pmask);
  assign tick     = step && (sub == 2'b11);
  assign wrap     = tick && (tmr_q == per_q);
  assign base     = {tmr_q, sub};
  assign act      = {act_hi_q, act_lo_q};
  assign pend     = {dhi_q, dlo_q};
  assign wr_ctrl  = reg_we && (reg_addr == 3'd2);
  assign psel_chg = wr_ctrl && (reg_wdata[3:2] != psel_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q  <= '0;
      dhi_q  <= '0;
      dlo_q  <= '0;
      psel_q <= '0;
      run_q  <= 1'b0;
      oe_q   <= 1'b0;
    end else if (reg_we) begin
      case (reg_addr)
        3'd0: per_q <= reg_wdata[TW-1:0];
        3'd1: dhi_q <= reg_wdata[TW-1:0];
        3'd2: begin
          dlo_q  <= reg_wdata[1:0];
          psel_q <= reg_wdata[3:2];
          run_q  <= reg_wdata[4];
          oe_q   <= reg_wdata[5];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (psel_chg) cnt_q <= '0;
    else if (run_q)    cnt_q <= tick ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    tmr_q <= '0;
    else if (tick) tmr_q <= wrap ? '0 : tmr_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_hi_q <= '0;
      act_lo_q <= '0;
    end else if (wrap) begin
      act_hi_q <= dhi_q;
      act_lo_q <= dlo_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                    pwm_q <= 1'b0;
    else if (wrap)                                 pwm_q <= (pend != '0);
    else if (step && ((base + DW'(1)) == act))     pwm_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                          flag_q <= 1'b0;
    else if (wrap)                                       flag_q <= 1'b1;
    else if (reg_we && reg_addr == 3'd3 && reg_wdata[0]) flag_q <= 1'b0;
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      3'd0: reg_rdata[TW-1:0] = per_q;
      3'd1: reg_rdata[TW-1:0] = dhi_q;
      3'd2: reg_rdata[5:0]    = {oe_q, run_q, psel_q, dlo_q};
      3'd3: reg_rdata[0]      = flag_q;
      3'd4: reg_rdata[TW-1:0] = act_hi_q;
      3'd5: reg_rdata[1:0]    = act_lo_q;
      default: ;
    endcase
  end

  assign pwm_out    = pwm_q;
  assign pwm_oe     = oe_q;
  assign period_irq = flag_q;

  assert_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (tmr_q == '0) && flag_q);

  assert_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> act == $past(pend));

  assert_hold_act_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(act));

  assert_zero_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (act == '0) |-> !pwm_q);

  assert_full_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_q && !wrap && (act > {per_q, 2'b11})) |=> pwm_q);

  assert_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> $stable(tmr_q) && $stable(pwm_q));
endmodule

// File: tb/sim_pwm10_gen.sv
`timescale 1ns/1ps
module sim_pwm10_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       pwm_out, pwm_oe, period_irq;
  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  pwm10_gen u0 (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out),
    .pwm_oe(pwm_oe), .period_irq(period_irq));

  always #5 clk = ~clk;

  task automatic chk(input string tag, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      miscompares++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    reg_we = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic wait_flag();
    reg_we = 1'b0; reg_addr = 3'd3;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      #1;
      if (reg_rdata[0]) return;
    end
    chk("R2 boundary flag timeout", 0, 1);
  endtask

  task automatic measure(input bit mid, input logic [7:0] mval, output int len, output int hi);
    len = 0; hi = 0;
    reg_we = 1'b1; reg_addr = 3'd3; reg_wdata = 8'h01;
    forever begin
      hi += int'(pwm_out);
      len++;
      @(negedge clk);
      reg_we = 1'b0; reg_addr = 3'd3;
      #1;
      if (reg_rdata[0] || len > 20000) break;
      if (len == 1 && mid) begin
        reg_we = 1'b1; reg_addr = 3'd1; reg_wdata = mval;
      end
    end
  endtask

  initial begin
    #1_950_000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int v, len, hi, per, nsc, exph;
    int duties[7];
    do_reset();
    chk("R1 pwm_out", pwm_out, 0);
    chk("R1 pwm_oe", pwm_oe, 0);
    chk("R1 period_irq", period_irq, 0);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk($sformatf("R1 read addr %0d", a), v, 0);
    end

    for (int s = 0; s < 4; s++) begin
      for (int pi = 0; pi < 4; pi++) begin
        int pr;
        pr = (1 << pi) - 1;
        if (s == 3 && pr == 7) continue;
        nsc = 1 << (2 * s);
        per = 4 * nsc * (pr + 1);
        duties = '{0, 1, 2, 2 * (pr + 1) + 1, 4 * (pr + 1) - 1, 4 * (pr + 1), 1023};
        foreach (duties[k]) begin
          int d;
          d = duties[k];
          do_reset();
          wr(3'd0, 8'(pr));
          wr(3'd1, 8'(d >> 2));
          wr(3'd2, {2'b00, 1'b0, 1'b1, 2'(s), 2'(d & 3)});
          wait_flag();
          measure(1'b0, 8'h00, len, hi);
          if (d == 0) exph = 0;
          else if (d >= 4 * (pr + 1)) exph = per;
          else exph = d * nsc;
          chk($sformatf("R2 period s=%0d pr=%0d d=%0d", s, pr, d), len, per);
          if (d == 0)
            chk($sformatf("R4 high time s=%0d pr=%0d", s, pr), hi, exph);
          else if (d >= 4 * (pr + 1))
            chk($sformatf("R5 high time s=%0d pr=%0d d=%0d", s, pr, d), hi, exph);
          else
            chk($sformatf("R3 high time s=%0d pr=%0d d=%0d", s, pr, d), hi, exph);
          chk($sformatf("R3 start level d=%0d", d), pwm_out, (d != 0) ? 1 : 0);
          rd(3'd4, v);
          chk("R6 active upper byte", v, d >> 2);
          rd(3'd5, v);
          chk("R6 active low bits", v, d & 3);
        end
      end
    end

    do_reset();
    wr(3'd0, 8'd3);
    wr(3'd1, 8'd1);
    wr(3'd2, 8'b0001_0001);
    wait_flag();
    rd(3'd4, v);
    chk("R6 active before mid write", v, 1);
    measure(1'b1, 8'd3, len, hi);
    chk("R6 current period keeps old duty", hi, 5);
    rd(3'd4, v);
    chk("R6 new duty latched at boundary", v, 3);
    measure(1'b0, 8'h00, len, hi);
    chk("R6 next period uses new duty", hi, 13);

    wr(3'd4, 8'hFF);
    wr(3'd5, 8'h02);
    rd(3'd4, v);
    chk("R7 active upper unchanged", v, 3);
    rd(3'd5, v);
    chk("R7 active low unchanged", v, 1);

    wait_flag();
    wr(3'd3, 8'h00);
    rd(3'd3, v);
    chk("R8 write of 0 keeps flag", v & 1, 1);
    chk("R8 period_irq mirrors flag", period_irq, 1);
    wr(3'd3, 8'h01);
    rd(3'd3, v);
    chk("R8 write of 1 clears flag", v & 1, 0);

    for (int c = 0; c < 3; c++) @(negedge clk);
    wr(3'd2, 8'b0000_0001);
    wr(3'd3, 8'h01);
    begin
      int lvl, moved;
      lvl = pwm_out; moved = 0;
      for (int c = 0; c < 60; c++) begin
        @(negedge clk);
        if (pwm_out != lvl || period_irq) moved = 1;
      end
      chk("R9 frozen while stopped", moved, 0);
    end

    wr(3'd2, 8'b0010_0001);
    chk("R10 output enable on", pwm_oe, 1);
    wr(3'd2, 8'b0000_0001);
    chk("R10 output enable off", pwm_oe, 0);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule